// File: doc/BRIEF.md
# Double-Banded Layer Compositing Buffer

This block collects image-layer pixels into a band of scan lines while a second band of equal size is streamed to the display. The upstream pipeline delivers layers sorted nearest-first. Each pixel carries an RGB colour, an alpha value and a position within the band. A per-pixel coverage (alpha) store records how much of each pixel is already covered. Every later layer can only fill the part that is still uncovered, so the colour store holds a front-to-back "over" composite when the band is finished.

The compositing side runs through a four-state machine. `ST_IDLE` moves to `ST_CLEAR` when `band_start` arrives. `ST_CLEAR` zeroes every colour and coverage location of the compositing bank, one per cycle, then moves to `ST_COMPOSE`. In `ST_COMPOSE` the block accepts pixels until `band_done` moves it to `ST_READY`. `ST_READY` returns to `ST_IDLE` on a swap.

The display side pulls one pixel per request in raster order. At the final pixel of its band, the banks trade roles if the compositor is in `ST_READY`. Otherwise the displayed band is repeated and an underrun flag is raised.

Top module: `cbuf_top`

## Requirements
- R1: After reset, `comp_idle`=1, `comp_ready`=0, `underrun`=0, `shown_bank`=0, `disp_valid`=0 and `disp_last`=0.
- R2: A `band_start` pulse in `ST_IDLE` clears every colour and coverage location of the compositing bank (the bank not shown). `comp_ready` goes high exactly NPIX+1 cycles after the cycle in which `band_start` was sampled, where NPIX = PIX_PER_LINE*BAND_LINES. Pixels never written in that band read back as zero.
- R3: Pixel index = `px_y`*PIX_PER_LINE + `px_x`. `px_rgb` holds red in [23:16], green in [15:8] and blue in [7:0]. An accepted pixel with alpha a over stored coverage c gets weight w = round(a*(255-c)/255). Each channel becomes min(255, old + round(ch*w/255)).
- R4: The coverage of an accepted pixel becomes min(255, c + w), so later layers at that pixel are scaled by the reduced remaining coverage.
- R5: A pixel whose coverage is already 255 leaves colour and coverage unchanged for any further layer.
- R6: `px_valid` has no effect unless `comp_ready` is high (state `ST_COMPOSE`).
- R7: Each cycle with `disp_req` high reads the next pixel of the shown band in raster order. The data appears on `disp_rgb` with `disp_valid` one cycle later, and `disp_last` marks the final pixel of the band.
- R8: On the request for the final pixel of a band, if the compositor is in `ST_READY`, `shown_bank` toggles, the compositor returns to `ST_IDLE` and `underrun` clears.
- R9: On that final request without `ST_READY`, `underrun` is set, `shown_bank` is unchanged and the same band content is shown again.
- R10: `band_done` has effect only in `ST_COMPOSE`. `band_start` has effect only in `ST_IDLE`; during `ST_COMPOSE` it does not restart clearing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| band_start | input | 1 | Begin a new compositing band |
| band_done | input | 1 | Compositing of the current band finished |
| px_valid | input | 1 | Layer pixel present |
| px_x | input | $clog2(PIX_PER_LINE) | Pixel column in band |
| px_y | input | $clog2(BAND_LINES) | Pixel line in band |
| px_rgb | input | 3*CW | Pixel colour, red high |
| px_alpha | input | CW | Pixel alpha |
| comp_ready | output | 1 | Compositor accepts pixels |
| comp_idle | output | 1 | Compositor waits for a band start |
| disp_req | input | 1 | Display pulls next pixel |
| disp_valid | output | 1 | Display pixel present |
| disp_rgb | output | 3*CW | Display pixel colour |
| disp_last | output | 1 | Final pixel of band |
| underrun | output | 1 | Previous band repeated |
| shown_bank | output | 1 | Bank being displayed |

## Verification
The bench stacks several layers on single pixels: fully opaque first, then transparent, then partial weights that must shrink with each added layer. A design that ignored prior coverage, or let an opaque pixel be overwritten, would show the wrong colour when the band is displayed.

It lets the display finish a band both with and without a completed composite. A swap taken without `ST_READY` would show a half-built band. A missed swap would keep an old band on screen with no underrun flag.

It reuses a bank that held content and writes only three pixels. A clear that skipped locations would leak stale colour. Writes issued after `band_done` must not appear, and a clear walk of the wrong length is caught by the exact count to `comp_ready`.

// File: rtl/cbuf_pkg.sv
package cbuf_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_CLEAR   = 2'd1,
        ST_COMPOSE = 2'd2,
        ST_READY   = 2'd3
    } comp_state_t;

endpackage

// File: rtl/cbuf_scale.sv
// Rounded division of a product by the full-scale value (2^CW - 1).
module cbuf_scale #(
    parameter int CW = 8
) (
    input  logic [2*CW-1:0] prod,
    output logic [CW-1:0]   quot
);
    localparam int PW   = 2 * CW;
    localparam int MAXV = (1 << CW) - 1;

    generate
        if (CW == 8) begin : g_shift
            // Add-and-shift form, exact for any product of two 8-bit values.
            logic [PW:0] biased;
            logic [PW:0] folded;
            assign biased = {1'b0, prod} + (PW+1)'(128);
            assign folded = biased + (biased >> 8);
            assign quot   = CW'(folded >> 8);
        end else begin : g_div
            logic [PW+1:0] num;
            assign num  = {prod, 1'b0} + (PW+2)'(MAXV);
            assign quot = CW'(num / (PW+2)'(2 * MAXV));
        end
    endgenerate

endmodule

// File: rtl/cbuf_blend.sv
// Front-to-back blend of one layer pixel over the stored colour and coverage.
module cbuf_blend #(
    parameter int CW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en,
    input  logic [3*CW-1:0] old_rgb,
    input  logic [CW-1:0]   old_cov,
    input  logic [3*CW-1:0] in_rgb,
    input  logic [CW-1:0]   in_alpha,
    output logic [3*CW-1:0] new_rgb,
    output logic [CW-1:0]   new_cov,
    output logic            full
);
    localparam int PW   = 2 * CW;
    localparam int MAXV = (1 << CW) - 1;

    logic [CW-1:0] room;
    logic [PW-1:0] w_prod;
    logic [CW-1:0] weight;
    logic [CW:0]   cov_sum;
    logic [CW-1:0] cov_sat;
    logic [3*CW-1:0] rgb_sum;

    assign full   = (old_cov == CW'(MAXV));
    assign room   = CW'(MAXV) - old_cov;
    assign w_prod = PW'(in_alpha) * PW'(room);

    cbuf_scale #(.CW(CW)) u_wscale (
        .prod (w_prod),
        .quot (weight)
    );

    assign cov_sum = {1'b0, old_cov} + {1'b0, weight};
    assign cov_sat = cov_sum[CW] ? CW'(MAXV) : cov_sum[CW-1:0];

    genvar ch;
    generate
        for (ch = 0; ch < 3; ch++) begin : g_chan
            logic [PW-1:0] c_prod;
            logic [CW-1:0] c_add;
            logic [CW:0]   c_sum;
            assign c_prod = PW'(in_rgb[ch*CW +: CW]) * PW'(weight);
            cbuf_scale #(.CW(CW)) u_cscale (
                .prod (c_prod),
                .quot (c_add)
            );
            assign c_sum = {1'b0, old_rgb[ch*CW +: CW]} + {1'b0, c_add};
            assign rgb_sum[ch*CW +: CW] = c_sum[CW] ? CW'(MAXV) : c_sum[CW-1:0];
        end
    endgenerate

    always_comb begin
        if (full) begin
            new_rgb = old_rgb;
            new_cov = old_cov;
        end else begin
            new_rgb = rgb_sum;
            new_cov = cov_sat;
        end
    end

    AST_COV_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
        en |-> (new_cov >= old_cov)) else $error("coverage shrank"); // R4
    AST_OPAQUE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (en && old_cov == CW'(MAXV)) |-> (new_rgb == old_rgb)) else $error("opaque pixel changed"); // R5

endmodule

// File: rtl/cbuf_bank.sv
// Storage array with one write port and NRD asynchronous read ports.
module cbuf_bank #(
    parameter int DW    = 24,
    parameter int DEPTH = 512,
    parameter int NRD   = 2,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic                    clk,
    input  logic                    we,
    input  logic [AW-1:0]           waddr,
    input  logic [DW-1:0]           wdata,
    input  logic [NRD-1:0][AW-1:0]  raddr,
    output logic [NRD-1:0][DW-1:0]  rdata
);
    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    genvar r;
    generate
        for (r = 0; r < NRD; r++) begin : g_rd
            assign rdata[r] = mem[raddr[r]];
        end
    endgenerate

endmodule

// File: rtl/cbuf_ctrl.sv
// Compositor state machine, clear walker, display counter and bank swap.
module cbuf_ctrl
    import cbuf_pkg::*;
#(
    parameter int NPIX = 512,
    localparam int AW  = $clog2(NPIX)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          band_start,
    input  logic          band_done,
    input  logic          disp_req,
    output logic          comp_ready,
    output logic          comp_idle,
    output logic          clearing,
    output logic [AW-1:0] clr_addr,
    output logic [AW-1:0] disp_addr,
    output logic          disp_bank,
    output logic          underrun,
    output logic          end_of_band
);
    localparam logic [AW-1:0] LAST = AW'(NPIX - 1);

    comp_state_t state, state_nx;

    assign end_of_band = disp_req && (disp_addr == LAST);

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // Transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:    if (band_start)         state_nx = ST_CLEAR;
            ST_CLEAR:   if (clr_addr == LAST)   state_nx = ST_COMPOSE;
            ST_COMPOSE: if (band_done)          state_nx = ST_READY;
            ST_READY:   if (end_of_band)        state_nx = ST_IDLE;
        endcase
    end

    // Outputs decoded from the state
    always_comb begin
        comp_ready = 1'b0;
        comp_idle  = 1'b0;
        clearing   = 1'b0;
        unique case (state)
            ST_IDLE:    comp_idle  = 1'b1;
            ST_CLEAR:   clearing   = 1'b1;
            ST_COMPOSE: comp_ready = 1'b1;
            ST_READY:   ;
        endcase
    end

    // Clear walker
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clr_addr <= '0;
        end else if (state == ST_CLEAR) begin
            clr_addr <= (clr_addr == LAST) ? '0 : clr_addr + 1'b1;
        end else begin
            clr_addr <= '0;
        end
    end

    // Display raster counter, bank selection and underrun
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            disp_addr <= '0;
            disp_bank <= 1'b0;
            underrun  <= 1'b0;
        end else begin
            if (disp_req) begin
                disp_addr <= (disp_addr == LAST) ? '0 : disp_addr + 1'b1;
            end
            if (end_of_band) begin
                if (state == ST_READY) begin
                    disp_bank <= ~disp_bank;
                    underrun  <= 1'b0;
                end else begin
                    underrun  <= 1'b1;
                end
            end
        end
    end

    AST_SWAP_ONLY_READY: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(disp_bank) |-> ($past(state) == ST_READY)) else $error("swap without ready"); // R8
    AST_UNDERRUN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(underrun) |-> $stable(disp_bank)) else $error("bank moved on underrun"); // R9
    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_COMPOSE && band_start && !band_done) |=> (state == ST_COMPOSE)) else $error("restart in compose"); // R10

endmodule

// File: rtl/cbuf_top.sv
module cbuf_top #(
    parameter int CW           = 8,
    parameter int PIX_PER_LINE = 16,
    parameter int BAND_LINES   = 32,
    localparam int XW   = $clog2(PIX_PER_LINE),
    localparam int YW   = $clog2(BAND_LINES),
    localparam int NPIX = PIX_PER_LINE * BAND_LINES,
    localparam int AW   = $clog2(NPIX),
    localparam int RW   = 3 * CW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          band_start,
    input  logic          band_done,
    input  logic          px_valid,
    input  logic [XW-1:0] px_x,
    input  logic [YW-1:0] px_y,
    input  logic [RW-1:0] px_rgb,
    input  logic [CW-1:0] px_alpha,
    output logic          comp_ready,
    output logic          comp_idle,
    input  logic          disp_req,
    output logic          disp_valid,
    output logic [RW-1:0] disp_rgb,
    output logic          disp_last,
    output logic          underrun,
    output logic          shown_bank
);
    logic          clearing;
    logic [AW-1:0] clr_addr;
    logic [AW-1:0] disp_addr;
    logic          disp_bank;
    logic          end_of_band;
    logic          comp_bank;
    logic [AW-1:0] pix_addr;
    logic [AW-1:0] wr_addr;
    logic          px_take;
    logic          wr_go;
    logic          full;
    logic [RW-1:0] blend_rgb;
    logic [CW-1:0] blend_cov;
    logic [RW-1:0] col_wdata;
    logic [CW-1:0] cov_wdata;
    logic [RW-1:0] comp_old_rgb;
    logic [RW-1:0] disp_rd_rgb;

    logic [1:0][1:0][RW-1:0] col_rd;
    logic [0:0][AW-1:0]      cov_raddr;
    logic [0:0][CW-1:0]      cov_rd;

    cbuf_ctrl #(.NPIX(NPIX)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .band_start  (band_start),
        .band_done   (band_done),
        .disp_req    (disp_req),
        .comp_ready  (comp_ready),
        .comp_idle   (comp_idle),
        .clearing    (clearing),
        .clr_addr    (clr_addr),
        .disp_addr   (disp_addr),
        .disp_bank   (disp_bank),
        .underrun    (underrun),
        .end_of_band (end_of_band)
    );

    assign comp_bank = ~disp_bank;
    assign pix_addr  = AW'(px_y) * AW'(PIX_PER_LINE) + AW'(px_x);
    assign px_take   = px_valid && comp_ready;
    assign wr_go     = clearing || (px_take && !full);
    assign wr_addr   = clearing ? clr_addr : pix_addr;
    assign col_wdata = clearing ? '0 : blend_rgb;
    assign cov_wdata = clearing ? '0 : blend_cov;

    assign comp_old_rgb = col_rd[comp_bank][0];
    assign disp_rd_rgb  = col_rd[disp_bank][1];

    genvar b;
    generate
        for (b = 0; b < 2; b++) begin : g_bank
            logic [1:0][AW-1:0] rd_addr;
            assign rd_addr[0] = pix_addr;
            assign rd_addr[1] = disp_addr;
            cbuf_bank #(.DW(RW), .DEPTH(NPIX), .NRD(2)) u_col (
                .clk   (clk),
                .we    (wr_go && (comp_bank == 1'(b))),
                .waddr (wr_addr),
                .wdata (col_wdata),
                .raddr (rd_addr),
                .rdata (col_rd[b])
            );
        end
    endgenerate

    assign cov_raddr[0] = pix_addr;

    cbuf_bank #(.DW(CW), .DEPTH(NPIX), .NRD(1)) u_cov (
        .clk   (clk),
        .we    (wr_go),
        .waddr (wr_addr),
        .wdata (cov_wdata),
        .raddr (cov_raddr),
        .rdata (cov_rd)
    );

    cbuf_blend #(.CW(CW)) u_blend (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (px_take),
        .old_rgb  (comp_old_rgb),
        .old_cov  (cov_rd[0]),
        .in_rgb   (px_rgb),
        .in_alpha (px_alpha),
        .new_rgb  (blend_rgb),
        .new_cov  (blend_cov),
        .full     (full)
    );

    // Registered display read
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            disp_valid <= 1'b0;
            disp_last  <= 1'b0;
            disp_rgb   <= '0;
        end else begin
            disp_valid <= disp_req;
            disp_last  <= end_of_band;
            if (disp_req) begin
                disp_rgb <= disp_rd_rgb;
            end
        end
    end

    assign shown_bank = disp_bank;

    AST_DISP_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        disp_req |=> disp_valid) else $error("request without data"); // R7
    AST_LAST_IS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        disp_last |-> disp_valid) else $error("last without data"); // R7
    AST_NO_WRITE_OUTSIDE: assert property (@(posedge clk) disable iff (!rst_n)
        (px_valid && comp_idle) |=> !comp_ready) else $error("idle write opened compose"); // R6

endmodule

// File: tb/cbuf_top_test.sv
module cbuf_top_test;
    localparam int CLK_PERIOD = 10;
    localparam int W     = 16;
    localparam int LINES = 32;
    localparam int NPIX  = W * LINES;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic band_start = 1'b0;
    logic band_done = 1'b0;
    logic px_valid = 1'b0;
    logic [3:0] px_x = '0;
    logic [4:0] px_y = '0;
    logic [23:0] px_rgb = '0;
    logic [7:0] px_alpha = '0;
    logic comp_ready, comp_idle;
    logic disp_req = 1'b0;
    logic disp_valid;
    logic [23:0] disp_rgb;
    logic disp_last, underrun, shown_bank;

    cbuf_top #(.CW(8), .PIX_PER_LINE(W), .BAND_LINES(LINES)) uut (
        .clk(clk), .rst_n(rst_n), .band_start(band_start), .band_done(band_done),
        .px_valid(px_valid), .px_x(px_x), .px_y(px_y), .px_rgb(px_rgb),
        .px_alpha(px_alpha), .comp_ready(comp_ready), .comp_idle(comp_idle),
        .disp_req(disp_req), .disp_valid(disp_valid), .disp_rgb(disp_rgb),
        .disp_last(disp_last), .underrun(underrun), .shown_bank(shown_bank)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int total = 0;
    int bad = 0;
    int exp_c [2][NPIX];
    int exp_a [NPIX];
    int sb = 0;
    int exp_ur = 0;
    bit composing = 0;
    bit ready_exp = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    function automatic int rdiv(input int x);
        return (2 * x + 255) / 510;
    endfunction

    function automatic int imin(input int a, input int b);
        return (a < b) ? a : b;
    endfunction

    task automatic model_put(input int idx, input int rgb, input int a);
        int cb = 1 - sb;
        int acc = exp_a[idx];
        int w, nv;
        if (acc == 255) return;
        w = rdiv(a * (255 - acc));
        nv = 0;
        for (int ch = 0; ch < 3; ch++) begin
            int o = (exp_c[cb][idx] >> (8 * ch)) & 255;
            int c = (rgb >> (8 * ch)) & 255;
            nv |= imin(255, o + rdiv(c * w)) << (8 * ch);
        end
        exp_c[cb][idx] = nv;
        exp_a[idx] = imin(255, acc + w);
    endtask

    task automatic put(input int x, input int y, input int rgb, input int a);
        @(negedge clk);
        px_valid = 1'b1;
        px_x = 4'(x);
        px_y = 5'(y);
        px_rgb = 24'(rgb);
        px_alpha = 8'(a);
        if (composing) model_put(y * W + x, rgb, a);
    endtask

    task automatic put_end();
        @(negedge clk);
        px_valid = 1'b0;
    endtask

    task automatic start_band();
        int cnt;
        @(negedge clk);
        band_start = 1'b1;
        @(negedge clk);
        band_start = 1'b0;
        cnt = 1;
        while (!comp_ready && cnt < 4 * NPIX) begin
            @(negedge clk);
            cnt++;
        end
        chk(cnt == NPIX + 1, "R2 clear length", cnt, NPIX + 1);
        for (int i = 0; i < NPIX; i++) begin
            exp_c[1 - sb][i] = 0;
            exp_a[i] = 0;
        end
        composing = 1;
    endtask

    task automatic finish_band();
        @(negedge clk);
        band_done = 1'b1;
        @(negedge clk);
        band_done = 1'b0;
        composing = 0;
        ready_exp = 1;
        chk(comp_ready == 1'b0, "R10 leave compose", comp_ready, 0);
    endtask

    task automatic check_prev(input int p, input bit do_chk, input int bank, input string tag);
        if (p < 0) begin
            chk(disp_valid == 1'b0, "R7 idle valid", disp_valid, 0);
        end else begin
            chk(disp_valid == 1'b1, "R7 valid", disp_valid, 1);
            chk(disp_last == (p == NPIX - 1), "R7 last", disp_last, (p == NPIX - 1));
            if (do_chk)
                chk(int'(disp_rgb) == exp_c[bank][p], tag, disp_rgb, exp_c[bank][p]);
        end
    endtask

    task automatic show_band(input bit do_chk, input bit gaps, input string tag);
        int pend = -1;
        int bank = sb;
        for (int i = 0; i < NPIX; i++) begin
            if (gaps && ($urandom % 4) == 0) begin
                @(negedge clk);
                check_prev(pend, do_chk, bank, tag);
                pend = -1;
                disp_req = 1'b0;
            end
            @(negedge clk);
            check_prev(pend, do_chk, bank, tag);
            disp_req = 1'b1;
            pend = i;
        end
        @(negedge clk);
        check_prev(pend, do_chk, bank, tag);
        disp_req = 1'b0;
        if (ready_exp) begin
            sb = 1 - sb;
            exp_ur = 0;
            ready_exp = 0;
            chk(comp_idle == 1'b1, "R8 back to idle", comp_idle, 1);
            chk(int'(shown_bank) == sb, "R8 swap", shown_bank, sb);
        end else begin
            exp_ur = 1;
            chk(int'(shown_bank) == sb, "R9 no swap", shown_bank, sb);
        end
        chk(int'(underrun) == exp_ur, "R8 R9 underrun", underrun, exp_ur);
    endtask

    task automatic random_layers(input int n);
        for (int k = 0; k < n; k++) begin
            int y = (k % 2 == 0) ? int'($urandom % 3) : int'($urandom % LINES);
            int a = (($urandom % 5) == 0) ? 255 : int'($urandom % 256);
            put(int'($urandom % W), y, int'($urandom % 24'hFFFFFF), a);
        end
        put_end();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4321));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(comp_idle == 1'b1, "R1 comp_idle", comp_idle, 1);
        chk(comp_ready == 1'b0, "R1 comp_ready", comp_ready, 0);
        chk(underrun == 1'b0, "R1 underrun", underrun, 0);
        chk(shown_bank == 1'b0, "R1 shown_bank", shown_bank, 0);
        chk(disp_valid == 1'b0, "R1 disp_valid", disp_valid, 0);
        chk(disp_last == 1'b0, "R1 disp_last", disp_last, 0);

        // First band into bank 1 with directed stacks
        start_band();
        put(0, 0, 24'h102030, 255);     // opaque first
        put(0, 0, 24'hFFFFFF, 200);     // R5 ignored
        put(1, 0, 24'hABCDEF, 0);       // R3 zero alpha
        put(2, 0, 24'hFF8040, 128);     // R4 stack
        put(2, 0, 24'h00FF00, 128);
        put(2, 0, 24'h0000FF, 255);
        put(15, 31, 24'hFFFFFF, 77);
        put(0, 31, 24'h123456, 255);
        put_end();
        // R10 band_start during compose is ignored
        @(negedge clk);
        band_start = 1'b1;
        @(negedge clk);
        band_start = 1'b0;
        @(negedge clk);
        chk(comp_ready == 1'b1, "R10 start ignored", comp_ready, 1);
        random_layers(300);
        finish_band();
        // R6 writes after band_done are ignored
        put(3, 3, 24'hFFFFFF, 255);
        put(0, 1, 24'hFFFFFF, 255);
        put_end();

        show_band(1'b0, 1'b0, "R7 unchecked");
        show_band(1'b1, 1'b1, "R3 R4 R5 R6 R7 pixel");
        show_band(1'b1, 1'b0, "R9 repeat pixel");

        // Second band into bank 0
        start_band();
        random_layers(200);
        finish_band();
        show_band(1'b1, 1'b0, "R9 R8 old band pixel");
        show_band(1'b1, 1'b1, "R3 R4 R7 bank0 pixel");

        // Third band reuses bank 1, sparse writes
        start_band();
        put(4, 4, 24'h808080, 255);
        put(5, 4, 24'h404040, 100);
        put(6, 20, 24'hF0F0F0, 30);
        put_end();
        finish_band();
        show_band(1'b1, 1'b0, "R8 bank0 pixel");
        show_band(1'b1, 1'b0, "R2 cleared pixel");

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule